// File: doc/BRIEF.md
# Time-Sliced Multi-Thread Checksum Core

This block is a 32-bit iterative checksum core whose next-state logic has been cut into C slices. A register level follows every slice, so the loop from the state register back to itself holds C registers instead of one. Each of those registers carries the state of a different thread. The result is C independent checksum engines that share one copy of the mixing logic, each advancing once every C clock cycles. Each clock cycle is called a micro-cycle.

A modulo-C thread counter names the thread that owns the current micro-cycle. In that cycle the core accepts the input word for the named thread and presents that thread's checksum on the output. Seen through its own slots, every thread behaves exactly like a single-thread core that runs one update per slot. Typical uses are running C unrelated streams through one datapath, or running C copies of one stream and comparing their outputs.

Top module: `cslow_core`

## Requirements
- R1: While `rst_n` is low, `data_out` is 0 and `thread_id` is 0. Asserting `rst_n` low at any time clears the state of every thread, so each thread shows 0 the first time its slot comes up after reset.
- R2: After reset, `thread_id` starts at 0 and advances by one on every micro-cycle. After it reaches C-1 it wraps to 0.
- R3: In the micro-cycle where `thread_id` equals j, the core takes `data_in` as thread j's input word. In that same micro-cycle, `data_out` shows thread j's current checksum.
- R4: Each slot updates the checksum of the thread that owns it by the rule S_next = g applied C times to (S xor data_in). The mixing round is g(t) = (t + rotate_left(t, 5)) xor (t >> 7), computed modulo 2^32. The new value appears on `data_out` C micro-cycles later, in that thread's next slot.
- R5: A round maps 0 to 0. A thread whose input word equals its current checksum therefore shows 0 in its next slot. A zero thread fed zero inputs stays 0.
- R6: Inputs given in one thread's slot never change the value that any other thread shows in its own slots.
- R7: C is a parameter with default 3 and a minimum of 2. The `thread_id` width is ceil(log2 C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Micro-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset of all threads and the counter |
| data_in | input | 32 | Input word for the thread named by `thread_id` in this cycle |
| data_out | output | 32 | Current checksum of the thread named by `thread_id` |
| thread_id | output | TID_W | Thread that owns the current micro-cycle |

## Verification
An input word given in thread j's slot affects no output until thread j's next slot, exactly C micro-cycles later. Its effect shows there as the new checksum on `data_out`. The bench keeps one reference checksum per thread, computed from the round rule. It drives inputs and samples outputs on the falling edge. For each slot it compares `data_out` against the reference of the thread it expects, before applying the update that only becomes visible C slots later. The checks on `thread_id` and on asynchronous reset look at the same falling-edge point and need no delay.

// File: rtl/cslow_pkg.sv
package cslow_pkg;

    parameter int DATA_W = 32;
    parameter int ROT_L  = 5;
    parameter int SHR    = 7;

    typedef logic [DATA_W-1:0] word_t;

    // One mixing round; maps zero to zero so cleared state is self-consistent.
    function automatic word_t mix_round(input word_t t);
        word_t rot;
        rot = (t << ROT_L) | (t >> (DATA_W - ROT_L));
        return (t + rot) ^ (t >> SHR);
    endfunction

endpackage

// File: rtl/cslow_thread_ctr.sv
module cslow_thread_ctr #(
    parameter int C     = 3,
    parameter int TID_W = (C > 1) ? $clog2(C) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] tid
);

    localparam logic [TID_W-1:0] LAST = TID_W'(C - 1);

    typedef struct packed {
        logic [TID_W-1:0] tid;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.tid == LAST) st_d.tid = '0;
        else                  st_d.tid = st_q.tid + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tid = st_q.tid;

    AST_TID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tid <= LAST);                                          // R2
    AST_TID_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tid == LAST) |=> (tid == '0));                        // R2

endmodule

// File: rtl/cslow_slice.sv
module cslow_slice
    import cslow_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t src,
    input  word_t inj,
    output word_t q
);

    typedef struct packed {
        word_t val;
    } slice_t;

    slice_t st_d, st_q;
    word_t  pre;

    always_comb begin
        pre      = FIRST ? (src ^ inj) : src;
        st_d     = st_q;
        st_d.val = mix_round(pre);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;

    AST_SLICE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pre == '0) |=> (q == '0));                            // R5

endmodule

// File: rtl/cslow_core.sv
module cslow_core
    import cslow_pkg::*;
#(
    parameter int C     = 3,
    parameter int TID_W = (C > 1) ? $clog2(C) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [TID_W-1:0]  thread_id
);

    // R7: at least two slices are required for time sharing.
    if (C < 2) begin : g_bad_c
        $error("cslow_core: C must be at least 2");
    end

    // lvl_q[k] is the register after slice k; lvl_q[C-1] is the state register.
    word_t lvl_q [C];

    for (genvar k = 0; k < C; k++) begin : g_slice
        if (k == 0) begin : g_head
            cslow_slice #(.FIRST(1'b1)) u_slice (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (lvl_q[C-1]),
                .inj   (data_in),
                .q     (lvl_q[0])
            );
        end else begin : g_body
            cslow_slice #(.FIRST(1'b0)) u_slice (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (lvl_q[k-1]),
                .inj   (data_in),
                .q     (lvl_q[k])
            );
        end
    end

    cslow_thread_ctr #(.C(C), .TID_W(TID_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .tid   (thread_id)
    );

    assign data_out = lvl_q[C-1];

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(data_out));                                // R3
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (data_out == '0 && thread_id == '0));       // R1

endmodule

// File: tb/cslow_core_tb.sv
`timescale 1ns/1ps
module cslow_core_tb;

    localparam int C     = 3;
    localparam int TID_W = $clog2(C);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      data_in = '0;
    logic [31:0]      data_out;
    logic [TID_W-1:0] thread_id;

    int tests = 0;
    int fails = 0;
    int exp_tid = 0;
    logic [31:0] model [C];

    localparam logic [31:0] VEC [16] = '{
        32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678,
        32'hDEAD_BEEF, 32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
        32'h0F0F_0F0F, 32'hCAFE_F00D, 32'h0000_0080, 32'h7FFF_FFFF,
        32'h1357_9BDF, 32'h2468_ACE0, 32'h0000_0000, 32'hFEDC_BA98
    };

    always #4 clk = ~clk;

    cslow_core #(.C(C)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .data_out  (data_out),
        .thread_id (thread_id)
    );

    function automatic logic [31:0] rnd(input logic [31:0] t);
        return (t + {t[26:0], t[31:27]}) ^ (t >> 7);
    endfunction

    function automatic logic [31:0] upd(input logic [31:0] s, input logic [31:0] x);
        logic [31:0] t;
        t = s ^ x;
        for (int i = 0; i < C; i++) t = rnd(t);
        return t;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Check the current slot, drive its input, advance to the next slot.
    task automatic step(input logic [31:0] x, input string req);
        tests++;
        if (thread_id !== TID_W'(exp_tid)) begin
            fails++;
            $display("FAIL R2 thread_id actual=%0d expected=%0d", thread_id, exp_tid);
        end
        tests++;
        if (data_out !== model[exp_tid]) begin
            fails++;
            $display("FAIL %s thread %0d data_out actual=%h expected=%h",
                     req, exp_tid, data_out, model[exp_tid]);
        end
        data_in = x;
        model[exp_tid] = upd(model[exp_tid], x);
        exp_tid = (exp_tid + 1) % C;
        @(negedge clk);
    endtask

    task automatic check_reset_outputs(input string tag);
        tests++;
        if (data_out !== 32'h0 || thread_id !== '0) begin
            fails++;
            $display("FAIL R1 %s actual=%h/%0d expected=0/0", tag, data_out, thread_id);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        data_in = '0;
        #1;
        check_reset_outputs("during reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < C; i++) model[i] = '0;
        exp_tid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: each thread shows zero on its first slot after reset
        for (int i = 0; i < C; i++) step(32'h0, "R1");

        // R3 R4: stimulus table walked across all threads
        for (int i = 0; i < 16; i++) step(VEC[i], "R4");
        for (int i = 0; i < 2 * C; i++) step(32'h0, "R3");

        // R5: input equal to the thread's checksum cancels it to zero
        for (int i = 0; i < C; i++) step(data_out, "R5");
        for (int i = 0; i < C; i++) begin
            tests++;
            if (data_out !== 32'h0) begin
                fails++;
                $display("FAIL R5 cancel actual=%h expected=%h", data_out, 32'h0);
            end
            step(32'h0, "R5");
        end

        // R1: asynchronous reset mid-run
        for (int i = 0; i < 5; i++) step(VEC[i] ^ 32'h3C3C_0001, "R4");
        do_reset();
        for (int i = 0; i < 2 * C; i++) step(32'h0, "R1");

        // R6: only thread 1 receives nonzero input; others must stay zero
        for (int i = 0; i < 4 * C; i++) begin
            if (exp_tid != 1 && data_out !== 32'h0) begin
                tests++;
                fails++;
                $display("FAIL R6 thread %0d actual=%h expected=%h", exp_tid, data_out, 32'h0);
            end
            step((exp_tid == 1) ? VEC[i] | 32'h1 : 32'h0, "R6");
        end

        // R2: long run of counter wraps
        for (int i = 0; i < 5 * C; i++) step(32'hFFFF_FFFF, "R2");

        summary();
    end

endmodule